// File: doc/BRIEF.md
# Dual-Mode General Purpose Timer

This block is a word-addressed timer with two 16-bit halves, A and B. A configuration register decides what the halves are used for:

- **Configuration 0:** they are joined into one 32-bit countdown that runs on the input clock.
- **Configuration 1:** they form a 32-bit real-time counter that advances on an external once-per-second strobe. It wraps to zero after reaching a programmed 32-bit match value.
- **Configuration 4 and above:** the halves are split, and in this block they stay idle.

Software programs the block through a plain write port with a combinational read-back. It sets a load value, chooses one-shot or periodic operation, and turns on the enable bit. Events are reported through a raw status register and a masked interrupt line. A separate one-cycle trigger output lets other logic start work on each countdown expiry.

Top module: `gpt_top`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero, both counters are stopped, and `irq` and `trig` are low.
- R2: In configuration 0, a write that sets control bit 0 (when it was clear) loads the countdown with {B-load[15:0], A-load[15:0]}, with B-load as the upper half. Raw status bit 0 is then set on exactly the N-th clock edge after that write edge, where N is the loaded value.
- R3: When mode-A bit 0 is clear, the countdown reloads on expiry and sets raw status bit 0 again every N cycles.
- R4: When mode-A bit 0 is set, expiry clears control bit 0, and the countdown sets no further status.
- R5: When control bit 5 is set, `trig` is high for exactly the one cycle after each countdown expiry edge.
- R6: In configuration 1 with control bit 0 set, each `sec_tick` strobe increments the real-time counter. A value that would exceed the 32-bit match value becomes 0 instead, and every transition to 0 sets raw status bit 3.
- R7: `irq` is high exactly when raw status AND the interrupt mask is nonzero. Only mask bits in 0x77 can be written, and the masked status register (0x20) reads raw status AND mask.
- R8: Writing the clear register (0x24) clears each raw status bit written as 1, and the clear register reads back 0. If an expiry falls in the same cycle as the clear, the set wins.
- R9: When the configuration is below 4, a write to A-load (0x28) or A-match (0x30) also stores bits 31:16 into the B register (0x2C or 0x34), and reading the A register returns {B, A}. From configuration 4 upward, only bits 15:0 are stored and read.
- R10: Clearing control bit 0 stops the countdown. Setting it again restarts the countdown from the full load value.
- R11: The A-value register (0x48) returns the real-time counter in configuration 1 and 0 otherwise. The B-value register (0x4C) always reads 0.
- R12: In configurations 4 and above, neither counter runs and no status bit is set, even with control bits 0 and 8 set.

Register offsets: configuration 0x00, mode A 0x04, mode B 0x08, control 0x0C, mask 0x18, raw status 0x1C, masked status 0x20, clear 0x24, load A/B 0x28/0x2C, match A/B 0x30/0x34, prescale A/B 0x38/0x3C, prescale-match A/B 0x40/0x44, value A/B 0x48/0x4C.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; the countdown counts its cycles |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 8 | Byte address of the register accessed |
| wr_en | input | 1 | Write strobe, captured on the rising clock edge |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| sec_tick | input | 1 | One-cycle strobe, once per second |
| irq | output | 1 | Level interrupt: raw status AND mask is nonzero |
| trig | output | 1 | One-cycle pulse after each countdown expiry when enabled |

## Verification
A countdown expiry and a software write to the clear register can land on the same clock edge, and they pull raw status bit 0 in opposite directions. The bench runs a periodic countdown of five cycles. It times the clear write so that it takes effect on the tenth edge, which is the second expiry. It then expects bit 0 to still read 1, with a trigger pulse in that cycle. A clear one edge later must bring the bit and the interrupt down.

// File: rtl/gpt_pkg.sv
// Shared constants for the dual-mode timer: bus width and register byte offsets.
// Assumes an 8-bit byte address; only word-aligned offsets are decoded.
package gpt_pkg;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFF_CFG     = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_MODE_A  = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_MODE_B  = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_CTL     = 8'h0C;
    localparam logic [ADDR_W-1:0] OFF_IMR     = 8'h18;
    localparam logic [ADDR_W-1:0] OFF_RIS     = 8'h1C;
    localparam logic [ADDR_W-1:0] OFF_MIS     = 8'h20;
    localparam logic [ADDR_W-1:0] OFF_CLR     = 8'h24;
    localparam logic [ADDR_W-1:0] OFF_LOAD_A  = 8'h28;
    localparam logic [ADDR_W-1:0] OFF_LOAD_B  = 8'h2C;
    localparam logic [ADDR_W-1:0] OFF_MATCH_A = 8'h30;
    localparam logic [ADDR_W-1:0] OFF_MATCH_B = 8'h34;
    localparam logic [ADDR_W-1:0] OFF_PRE_A   = 8'h38;
    localparam logic [ADDR_W-1:0] OFF_PRE_B   = 8'h3C;
    localparam logic [ADDR_W-1:0] OFF_PMAT_A  = 8'h40;
    localparam logic [ADDR_W-1:0] OFF_PMAT_B  = 8'h44;
    localparam logic [ADDR_W-1:0] OFF_VAL_A   = 8'h48;
    localparam logic [ADDR_W-1:0] OFF_VAL_B   = 8'h4C;

    // Configuration codes the counters act on
    localparam int CFG_JOINED = 0;
    localparam int CFG_CLOCK  = 1;
    localparam int CFG_SPLIT  = 4;

    // Control, status and mode bit positions
    localparam int CTL_EN_A  = 0;
    localparam int CTL_TRG_A = 5;
    localparam int CTL_EN_B  = 8;
    localparam int ST_EXPIRE = 0;
    localparam int ST_WRAP   = 3;
    localparam int MODE_ONCE = 0;

    localparam logic [7:0] IMR_WRITABLE = 8'h77;
endpackage

// File: rtl/gpt_countdown.sv
// Joined 32-bit countdown. It loads on a start pulse and then decrements once
// per cycle while run is high. expire is raised in the cycle the count reaches
// 1 (or sits at 0), and the count reloads on the following edge.
// Assumes start and run are never both acted on in the same cycle; start wins.
module gpt_countdown #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         run,
    input  logic [W-1:0] load_val,
    output logic         expire
);
    logic [W-1:0] cnt;

    // Expiry is reached on the last counted cycle of a period
    assign expire = run && !start && (cnt <= W'(1));

    // Count register: load on start, reload on expiry, otherwise step down
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= load_val;
        end else if (run) begin
            cnt <= (cnt <= W'(1)) ? load_val : cnt - W'(1);
        end
    end
endmodule

// File: rtl/gpt_rtc.sv
// Real-time counter. It advances on each step strobe and returns to zero when
// the incremented value would exceed match. wrap flags the step that lands
// on zero. Assumes step is already qualified by configuration and enable.
module gpt_rtc #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic [W-1:0] match,
    output logic [W-1:0] value,
    output logic         wrap
);
    logic [W-1:0] inc;
    logic [W-1:0] nxt;

    // Next counter value with wrap past the match value
    always_comb begin
        inc = value + W'(1);
        nxt = (inc > match) ? '0 : inc;
    end

    assign wrap = step && (nxt == '0);

    // Counter register advanced only on qualified strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= '0;
        end else if (step) begin
            value <= nxt;
        end
    end
endmodule

// File: rtl/gpt_regs.sv
// Register file and bus decode of the timer. It holds the configuration,
// mode, control, mask, status, load, match and prescale registers, merges
// the counters' events into the status register, and drives the trigger
// pulse. Assumes a single-cycle write strobe and a combinational read.
module gpt_regs
    import gpt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CFG_W  = 3,
    parameter int MODE_W = 4,
    parameter int CTL_W  = 16,
    parameter int STAT_W = 8,
    parameter int PRE_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              cd_expire,
    input  logic              rtc_wrap,
    input  logic [DATA_W-1:0] rtc_val,
    output logic [CFG_W-1:0]  cfg,
    output logic [MODE_W-1:0] mode_a,
    output logic [CTL_W-1:0]  ctl,
    output logic [STAT_W-1:0] ris,
    output logic [STAT_W-1:0] imr,
    output logic [DATA_W-1:0] load32,
    output logic [DATA_W-1:0] match32,
    output logic              start_a,
    output logic              trig
);
    localparam int HALF_W = DATA_W / 2;

    logic [MODE_W-1:0] mode_b;
    logic [HALF_W-1:0] load_a, load_b, match_a, match_b;
    logic [PRE_W-1:0]  pre_a, pre_b, pmat_a, pmat_b;
    logic              joined;
    logic              wr_ctl, wr_clr;
    logic [STAT_W-1:0] ris_nxt;

    assign joined  = cfg < CFG_W'(CFG_SPLIT);
    assign wr_ctl  = wr_en && (addr == OFF_CTL);
    assign wr_clr  = wr_en && (addr == OFF_CLR);
    assign start_a = wr_ctl && wdata[CTL_EN_A] && !ctl[CTL_EN_A];
    assign load32  = {load_b, load_a};
    assign match32 = {match_b, match_a};

    // Status update: clear by write first, then counter events set bits
    always_comb begin
        ris_nxt = ris;
        if (wr_clr) begin
            ris_nxt = ris_nxt & ~wdata[STAT_W-1:0];
        end
        if (cd_expire) begin
            ris_nxt[ST_EXPIRE] = 1'b1;
        end
        if (rtc_wrap) begin
            ris_nxt[ST_WRAP] = 1'b1;
        end
    end

    // Configuration, mode, mask and status registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg    <= '0;
            mode_a <= '0;
            mode_b <= '0;
            imr    <= '0;
            ris    <= '0;
        end else begin
            ris <= ris_nxt;
            if (wr_en) begin
                case (addr)
                    OFF_CFG:    cfg    <= wdata[CFG_W-1:0];
                    OFF_MODE_A: mode_a <= wdata[MODE_W-1:0];
                    OFF_MODE_B: mode_b <= wdata[MODE_W-1:0];
                    OFF_IMR:    imr    <= wdata[STAT_W-1:0] & IMR_WRITABLE[STAT_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    // Control register: software write wins over the one-shot auto-clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl <= '0;
        end else if (wr_ctl) begin
            ctl <= wdata[CTL_W-1:0];
        end else if (cd_expire && mode_a[MODE_ONCE]) begin
            ctl[CTL_EN_A] <= 1'b0;
        end
    end

    // Load, match and prescale registers with the joined-mode upper-half split
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_a  <= '0;
            load_b  <= '0;
            match_a <= '0;
            match_b <= '0;
            pre_a   <= '0;
            pre_b   <= '0;
            pmat_a  <= '0;
            pmat_b  <= '0;
        end else if (wr_en) begin
            case (addr)
                OFF_LOAD_A: begin
                    load_a <= wdata[HALF_W-1:0];
                    if (joined) load_b <= wdata[DATA_W-1:HALF_W];
                end
                OFF_LOAD_B: load_b <= wdata[HALF_W-1:0];
                OFF_MATCH_A: begin
                    match_a <= wdata[HALF_W-1:0];
                    if (joined) match_b <= wdata[DATA_W-1:HALF_W];
                end
                OFF_MATCH_B: match_b <= wdata[HALF_W-1:0];
                OFF_PRE_A:   pre_a   <= wdata[PRE_W-1:0];
                OFF_PRE_B:   pre_b   <= wdata[PRE_W-1:0];
                OFF_PMAT_A:  pmat_a  <= wdata[PRE_W-1:0];
                OFF_PMAT_B:  pmat_b  <= wdata[PRE_W-1:0];
                default: ;
            endcase
        end
    end

    // Trigger pulse: one cycle after each expiry edge when enabled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig <= 1'b0;
        end else begin
            trig <= cd_expire && ctl[CTL_TRG_A];
        end
    end

    // Read multiplexer
    always_comb begin
        rdata = '0;
        case (addr)
            OFF_CFG:     rdata = DATA_W'(cfg);
            OFF_MODE_A:  rdata = DATA_W'(mode_a);
            OFF_MODE_B:  rdata = DATA_W'(mode_b);
            OFF_CTL:     rdata = DATA_W'(ctl);
            OFF_IMR:     rdata = DATA_W'(imr);
            OFF_RIS:     rdata = DATA_W'(ris);
            OFF_MIS:     rdata = DATA_W'(ris & imr);
            OFF_LOAD_A:  rdata = joined ? load32 : DATA_W'(load_a);
            OFF_LOAD_B:  rdata = DATA_W'(load_b);
            OFF_MATCH_A: rdata = joined ? match32 : DATA_W'(match_a);
            OFF_MATCH_B: rdata = DATA_W'(match_b);
            OFF_PRE_A:   rdata = DATA_W'(pre_a);
            OFF_PRE_B:   rdata = DATA_W'(pre_b);
            OFF_PMAT_A:  rdata = DATA_W'(pmat_a);
            OFF_PMAT_B:  rdata = DATA_W'(pmat_b);
            OFF_VAL_A:   rdata = (cfg == CFG_W'(CFG_CLOCK)) ? rtc_val : '0;
            default:     rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpt_top.sv
// Dual-mode timer top. It connects the register file to the joined countdown
// and the real-time counter, qualifies each counter by configuration and
// enable, and forms the level interrupt.
// Assumes sec_tick is a synchronous one-cycle strobe.
module gpt_top
    import gpt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CFG_W  = 3,
    parameter int MODE_W = 4,
    parameter int CTL_W  = 16,
    parameter int STAT_W = 8,
    parameter int PRE_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              sec_tick,
    output logic              irq,
    output logic              trig
);
    logic [CFG_W-1:0]  cfg;
    logic [MODE_W-1:0] mode_a;
    logic [CTL_W-1:0]  ctl;
    logic [STAT_W-1:0] ris, imr;
    logic [DATA_W-1:0] load32, match32, rtc_val;
    logic              start_a, cd_expire, rtc_wrap, cd_run, rtc_step;

    assign cd_run   = ctl[CTL_EN_A] && (cfg == CFG_W'(CFG_JOINED));
    assign rtc_step = sec_tick && ctl[CTL_EN_A] && (cfg == CFG_W'(CFG_CLOCK));
    assign irq      = |(ris & imr);

    gpt_regs #(
        .DATA_W(DATA_W), .CFG_W(CFG_W), .MODE_W(MODE_W),
        .CTL_W(CTL_W), .STAT_W(STAT_W), .PRE_W(PRE_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
        .wdata(wdata), .rdata(rdata), .cd_expire(cd_expire),
        .rtc_wrap(rtc_wrap), .rtc_val(rtc_val), .cfg(cfg),
        .mode_a(mode_a), .ctl(ctl), .ris(ris), .imr(imr),
        .load32(load32), .match32(match32), .start_a(start_a), .trig(trig)
    );

    gpt_countdown #(.W(DATA_W)) u_cd (
        .clk(clk), .rst_n(rst_n), .start(start_a), .run(cd_run),
        .load_val(load32), .expire(cd_expire)
    );

    gpt_rtc #(.W(DATA_W)) u_rtc (
        .clk(clk), .rst_n(rst_n), .step(rtc_step), .match(match32),
        .value(rtc_val), .wrap(rtc_wrap)
    );
endmodule

// Property checker for gpt_top, attached by the bind below.
// Assumes it sees the top's internal event and register signals.
module gpt_chk
    import gpt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CFG_W  = 3,
    parameter int MODE_W = 4,
    parameter int CTL_W  = 16,
    parameter int STAT_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic [DATA_W-1:0] wdata,
    input logic [CFG_W-1:0]  cfg,
    input logic [MODE_W-1:0] mode_a,
    input logic [CTL_W-1:0]  ctl,
    input logic [STAT_W-1:0] ris,
    input logic [DATA_W-1:0] match32,
    input logic [DATA_W-1:0] rtc_val,
    input logic              cd_expire,
    input logic              rtc_step,
    input logic              trig
);
    // R5
    trig_has_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig |-> ris[ST_EXPIRE]);

    // R4
    oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cd_expire && mode_a[MODE_ONCE] && !(wr_en && addr == OFF_CTL)) |=> !ctl[CTL_EN_A]);

    // R8
    clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFF_CLR && wdata[ST_EXPIRE] && !cd_expire) |=> !ris[ST_EXPIRE]);

    // R6
    rtc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rtc_step && rtc_val == match32) |=> (rtc_val == '0 && ris[ST_WRAP]));

    // R12
    split_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg >= CFG_W'(CFG_SPLIT)) |-> (!cd_expire && !rtc_step));
endmodule

bind gpt_top gpt_chk #(
    .DATA_W(DATA_W), .CFG_W(CFG_W), .MODE_W(MODE_W), .CTL_W(CTL_W), .STAT_W(STAT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .cfg(cfg), .mode_a(mode_a), .ctl(ctl), .ris(ris), .match32(match32),
    .rtc_val(rtc_val), .cd_expire(cd_expire), .rtc_step(rtc_step), .trig(trig)
);

// File: tb/sim_gpt_top.sv
// Scoreboard bench for gpt_top: tasks queue expected values, a monitor
// compares them at the falling edge.
module sim_gpt_top;
    import gpt_pkg::*;

    typedef struct {
        int          kind;   // 0 rdata, 1 irq, 2 trig
        logic [31:0] exp;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        sec_tick = 1'b0;
    logic        irq, trig;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    item_t sb[$];

    always #5 clk = ~clk;

    gpt_top u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
        .rdata(rdata), .sec_tick(sec_tick), .irq(irq), .trig(trig)
    );

    // Monitor: drain the scoreboard against the outputs
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sb.pop_front();
            case (it.kind)
                1:       act = {31'b0, irq};
                2:       act = {31'b0, trig};
                default: act = rdata;
            endcase
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic step(input int k);
        repeat (k) @(posedge clk);
        #1;
    endtask

    task automatic exp_sig(input int kind, input logic [31:0] e, input string tag);
        item_t it;
        it.kind = kind; it.exp = e; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic exp_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        item_t it;
        addr = a;
        it.kind = 0; it.exp = e; it.tag = tag;
        sb.push_back(it);
        @(negedge clk); #1;
    endtask

    task automatic tick();
        sec_tick = 1'b1;
        @(posedge clk); #1;
        sec_tick = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        #(150000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        // R1 reset state
        exp_sig(1, 0, "R1 irq");
        exp_sig(2, 0, "R1 trig");
        exp_rd(OFF_CTL, 0, "R1 ctl");
        exp_rd(OFF_RIS, 0, "R1 ris");
        exp_rd(OFF_CFG, 0, "R1 cfg");
        // R7 mask writable bits
        wr(OFF_IMR, 32'hFFFF_FFFF);
        exp_rd(OFF_IMR, 32'h77, "R7 mask");
        // R9 joined split writes
        wr(OFF_LOAD_A, 32'h0003_0005);
        exp_rd(OFF_LOAD_B, 32'h3, "R9 load B");
        exp_rd(OFF_LOAD_A, 32'h0003_0005, "R9 load A");
        wr(OFF_MATCH_A, 32'h0001_0002);
        exp_rd(OFF_MATCH_B, 32'h1, "R9 match B");
        // R2/R3/R5 periodic countdown of 5 with trigger
        wr(OFF_LOAD_A, 32'h5);
        wr(OFF_MODE_A, 32'h0);
        wr(OFF_CTL, 32'h21);
        step(4);
        exp_rd(OFF_RIS, 0, "R2 before expiry");
        step(1);
        exp_sig(2, 1, "R5 trig high");
        exp_sig(1, 1, "R7 irq high");
        exp_rd(OFF_RIS, 1, "R2 expiry");
        step(1);
        exp_sig(2, 0, "R5 trig one cycle");
        exp_rd(OFF_MIS, 1, "R7 masked");
        step(3);
        wr(OFF_CLR, 32'h1);
        exp_sig(2, 1, "R3 second period trig");
        exp_rd(OFF_RIS, 1, "R8 set wins over clear");
        wr(OFF_CLR, 32'hFFFF_FFFF);
        exp_sig(1, 0, "R7 irq low");
        exp_rd(OFF_RIS, 0, "R8 clear");
        exp_rd(OFF_CLR, 0, "R8 clear reads zero");
        wr(OFF_CTL, 32'h0);
        step(12);
        exp_rd(OFF_RIS, 0, "R10 stopped");
        // R10 restart from full load
        wr(OFF_CTL, 32'h1);
        step(2);
        wr(OFF_CTL, 32'h0);
        wr(OFF_CTL, 32'h1);
        step(4);
        exp_rd(OFF_RIS, 0, "R10 restart no early expiry");
        step(1);
        exp_rd(OFF_RIS, 1, "R10 restart expiry");
        wr(OFF_CTL, 32'h0);
        wr(OFF_CLR, 32'hFF);
        // R4 one-shot
        wr(OFF_MODE_A, 32'h1);
        wr(OFF_LOAD_A, 32'h3);
        wr(OFF_CTL, 32'h1);
        step(3);
        exp_rd(OFF_CTL, 0, "R4 enable cleared");
        wr(OFF_CLR, 32'hFF);
        step(10);
        exp_rd(OFF_RIS, 0, "R4 no reload");
        // R2 full 32-bit period
        wr(OFF_LOAD_A, 32'h4);
        wr(OFF_LOAD_B, 32'h1);
        exp_rd(OFF_LOAD_A, 32'h0001_0004, "R9 combined read");
        wr(OFF_CTL, 32'h1);
        step(65539);
        exp_rd(OFF_RIS, 0, "R2 32-bit before");
        step(1);
        exp_rd(OFF_RIS, 1, "R2 32-bit expiry");
        wr(OFF_CLR, 32'hFF);
        exp_rd(OFF_VAL_A, 0, "R11 value zero in cfg 0");
        // R6 real-time counter wrap at match 2
        wr(OFF_CFG, 32'h1);
        wr(OFF_MATCH_A, 32'h2);
        wr(OFF_CTL, 32'h1);
        tick();
        exp_rd(OFF_VAL_A, 1, "R6 first tick");
        tick();
        exp_rd(OFF_VAL_A, 2, "R6 second tick");
        tick();
        exp_rd(OFF_VAL_A, 0, "R6 wrap");
        exp_rd(OFF_RIS, 32'h8, "R6 wrap status");
        exp_rd(OFF_VAL_B, 0, "R11 value B zero");
        step(5);
        exp_rd(OFF_VAL_A, 0, "R6 no tick no step");
        wr(OFF_CTL, 32'h0);
        wr(OFF_CLR, 32'hFF);
        // R12 split configuration stays idle
        wr(OFF_CFG, 32'h4);
        wr(OFF_LOAD_B, 32'h7);
        wr(OFF_LOAD_A, 32'hABCD_0002);
        exp_rd(OFF_LOAD_A, 32'h2, "R9 split low half only");
        exp_rd(OFF_LOAD_B, 32'h7, "R9 split B untouched");
        wr(OFF_CTL, 32'h121);
        tick();
        step(20);
        exp_sig(2, 0, "R12 no trigger");
        exp_rd(OFF_RIS, 0, "R12 no status");
        step(1);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule